// File: doc/BRIEF.md
# Frame-Synchronised Display Data Latch

This block keeps the segment image of a multiplexed LCD driver steady while a new image is being shifted in serially. It sees the parallel contents of the input shift register, the shift enable that frames a serial transfer, and a one-cycle frame tick produced by the display timing. It presents the stored image to the waveform logic. The image is organised as three banks of 32 bits, 96 bits in all, and each bit is one segment element. A stored 1 lights its element.

The shift enable comes from the serial side and is not tied to the display clock. It passes through a two-flop synchroniser, and its synchronised falling edge marks a new image as ready. The copy into the latch waits for the next frame tick, so an image never changes in the middle of a frame. A pending flag remembers that a new image exists. The flag clears on transfer, so later ticks do not repeat the copy. No transfer happens while a shift is in progress.

A drive-mode input sets how many 32-bit banks the display uses. Banks beyond that count are presented as zero at the output. Their stored contents are kept, so widening the mode later shows them again.

Top module: `display_frame_latch`

## Requirements
- R1: The latch holds NUM_BANKS x BANK_W bits (96 by default). `seg_image[i]` is driven from stored bit i alone, and a stored 1 means the element is on.
- R2: After reset, `seg_image` is all zeros and no transfer is pending.
- R3: While the synchronised shift enable is high, the stored image does not change, even if `frame_tick` pulses.
- R4: A new image is copied only on a clock edge at which `frame_tick` is high. Between the fall of the enable and that tick, `seg_image` keeps the old image.
- R5: A synchronised fall of the enable marks one transfer as pending, and the transfer clears it. Frame ticks with no new fall leave the image unchanged, even if `shift_data` has changed.
- R6: `shift_en` passes through a two-flop synchroniser. A tick applied three or more clock cycles after the enable goes low loads `shift_data`, and the result is visible after the clock edge that ends the tick cycle.
- R7: `drive_mode` is the number of active banks. 2'b00 shows nothing, 2'b01 shows bits 31:0, 2'b10 shows bits 63:0, and 2'b11 shows all 96 bits. Inactive banks read 0, and the stored bits are kept for when the mode widens.
- R8: A pending transfer survives a new rise of the enable. A tick while the enable is high again does not load. After the next fall, a tick loads the data present at that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shift_en | input | 1 | Serial shift enable, asynchronous; high while shifting |
| shift_data | input | 96 | Parallel contents of the input shift register |
| frame_tick | input | 1 | One-cycle frame boundary pulse |
| drive_mode | input | 2 | Number of active 32-bit banks (0 to 3) |
| seg_image | output | 96 | Latched segment image after bank masking |

## Verification
The hardest case to reach is a transfer that is pending while a new shift has already started. The enable has fallen, so the flag is set, but it has risen again before any frame tick. The bench reaches this case on purpose. It raises the enable a second time, waits for the synchroniser to pass it through, and then fires a tick that must do nothing. It then drops the enable and ticks again, expecting the newest data. Random rounds mix such rises held across a tick, single pulses, bare ticks and mode changes. They compare the output against a bench model of the stored image and the pending flag.

// File: rtl/dlat_pkg.sv
package dlat_pkg;

    // Drive mode value equals the number of active banks
    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_ONE     = 2'd1,
        MODE_TWO     = 2'd2,
        MODE_THREE   = 2'd3
    } drive_mode_e;

    // Number of banks shown for a mode, clipped to the banks present
    function automatic int unsigned banks_shown(input logic [1:0] mode,
                                                input int unsigned nbanks);
        int unsigned req;
        req = int'(mode);
        return (req > nbanks) ? nbanks : req;
    endfunction

endpackage

// File: rtl/dlat_en_sync.sv
module dlat_en_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] stg;
        logic              prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stg  = {st_q.stg[STAGES-2:0], async_in};
        st_d.prev = st_q.stg[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.stg[STAGES-1];
    assign fall_o  = st_q.prev & ~st_q.stg[STAGES-1];

endmodule

// File: rtl/dlat_xfer_ctrl.sv
module dlat_xfer_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic en_level,
    input  logic en_fall,
    input  logic frame_tick,
    output logic load_o,
    output logic pending_o
);

    typedef struct packed {
        logic pending;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        want;
    logic        load;

    always_comb begin
        want       = st_q.pending | en_fall;
        load       = frame_tick & ~en_level & want;
        st_d       = st_q;
        st_d.pending = want & ~load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o    = load;
    assign pending_o = st_q.pending;

endmodule

// File: rtl/dlat_bank_store.sv
module dlat_bank_store #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] bits;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.bits = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.bits;

endmodule

// File: rtl/display_frame_latch.sv
module display_frame_latch
    import dlat_pkg::*;
#(
    parameter int unsigned BANK_W      = 32,
    parameter int unsigned NUM_BANKS   = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          shift_en,
    input  logic [BANK_W*NUM_BANKS-1:0]   shift_data,
    input  logic                          frame_tick,
    input  logic [1:0]                    drive_mode,
    output logic [BANK_W*NUM_BANKS-1:0]   seg_image
);

    localparam int unsigned DATA_W = BANK_W * NUM_BANKS;

    logic              en_level;
    logic              en_fall;
    logic              load;
    logic              pending;
    logic [DATA_W-1:0] latch_q;
    int unsigned       shown;

    dlat_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (shift_en),
        .level_o  (en_level),
        .fall_o   (en_fall)
    );

    dlat_xfer_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_level   (en_level),
        .en_fall    (en_fall),
        .frame_tick (frame_tick),
        .load_o     (load),
        .pending_o  (pending)
    );

    always_comb begin
        shown = banks_shown(drive_mode, NUM_BANKS);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BANK_W-1:0] bank_q;

        dlat_bank_store #(.W(BANK_W)) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load),
            .din   (shift_data[b*BANK_W +: BANK_W]),
            .dout  (bank_q)
        );

        assign latch_q[b*BANK_W +: BANK_W]   = bank_q;
        assign seg_image[b*BANK_W +: BANK_W] =
            (b < shown) ? bank_q : '0;
    end

endmodule

// File: rtl/dlat_checker.sv
module dlat_checker #(
    parameter int unsigned BANK_W    = 32,
    parameter int unsigned NUM_BANKS = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        frame_tick,
    input logic [1:0]                  drive_mode,
    input logic [BANK_W*NUM_BANKS-1:0] seg_image,
    input logic                        en_level,
    input logic                        load,
    input logic                        pending,
    input logic [BANK_W*NUM_BANKS-1:0] latch
);

    localparam int unsigned DATA_W = BANK_W * NUM_BANKS;

    // R3: synchronised enable high freezes the stored image
    a_r3_hold_while_shift: assert property (@(posedge clk) disable iff (!rst_n)
        en_level |=> $stable(latch));

    // R4: stored image moves only at a frame tick
    a_r4_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(latch));

    // R5: a transfer leaves nothing pending
    a_r5_pending_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !pending);

    // R5: without a transfer the stored image is steady
    a_r5_no_load_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(latch));

    // R7: mode zero blanks everything
    a_r7_mode_off_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_mode == 2'd0) |-> (seg_image == '0));

    // R7: single-bank mode blanks the upper banks
    a_r7_mode_one_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_mode == 2'd1) |-> (seg_image[DATA_W-1:BANK_W] == '0));

    // R1: an element can be on only if its stored bit is one
    a_r1_on_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ((seg_image & ~latch) == '0));

endmodule

bind display_frame_latch dlat_checker #(
    .BANK_W    (BANK_W),
    .NUM_BANKS (NUM_BANKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .drive_mode (drive_mode),
    .seg_image  (seg_image),
    .en_level   (en_level),
    .load       (load),
    .pending    (pending),
    .latch      (latch_q)
);

// File: tb/display_frame_latch_tb.sv
module display_frame_latch_tb;

    localparam int unsigned BW = 32;
    localparam int unsigned NB = 3;
    localparam int unsigned DW = BW * NB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          shift_en = 1'b0;
    logic [DW-1:0] shift_data = '0;
    logic          frame_tick = 1'b0;
    logic [1:0]    drive_mode = 2'd3;
    logic [DW-1:0] seg_image;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] m_latch = '0;
    bit            m_pending = 1'b0;
    bit            m_en_high = 1'b0;

    always #2 clk = ~clk;

    display_frame_latch #(.BANK_W(BW), .NUM_BANKS(NB)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .shift_data (shift_data),
        .frame_tick (frame_tick),
        .drive_mode (drive_mode),
        .seg_image  (seg_image)
    );

    function automatic logic [DW-1:0] mode_mask(input logic [1:0] m);
        logic [DW-1:0] r;
        r = '0;
        for (int b = 0; b < NB; b++)
            if (b < int'(m)) r[b*BW +: BW] = '1;
        return r;
    endfunction

    function automatic logic [DW-1:0] rnd96();
        return {$urandom, $urandom, $urandom};
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [DW-1:0] exp);
        checks++;
        if (seg_image !== exp) begin
            errors++;
            $display("FAIL %s: seg_image=%h expected=%h", req, seg_image, exp);
        end
    endtask

    task automatic check_model(input string req);
        check(req, m_latch & mode_mask(drive_mode));
    endtask

    task automatic en_up();
        shift_en = 1'b1;
        step(3);
        m_en_high = 1'b1;
    endtask

    task automatic en_down();
        shift_en = 1'b0;
        step(4);
        m_en_high = 1'b0;
        m_pending = 1'b1;
    endtask

    task automatic tick();
        frame_tick = 1'b1;
        step(1);
        frame_tick = 1'b0;
        if (m_pending && !m_en_high) begin
            m_latch   = shift_data;
            m_pending = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] a_val, b_val, c_val, d_val;
        void'($urandom(32'h5EED_0022));
        a_val = 96'hA5A5_0F0F_1234_5678_9ABC_DEF0;
        b_val = 96'h0123_4567_89AB_CDEF_F0E1_D2C3;

        step(3);
        // R2: reset state
        check("R2 reset image", '0);
        rst_n = 1'b1;
        step(2);
        check("R2 after reset release", '0);

        // R3: tick during shift has no effect
        shift_data = a_val;
        en_up();
        tick();
        check_model("R3 tick while shifting");
        check("R3 image still zero", '0);

        // R4: no change between fall and tick
        en_down();
        step(5);
        check("R4 no update before tick", '0);

        // R6 / R1: tick loads data one edge later, bit for bit
        tick();
        check("R6 load after tick", a_val);
        check("R1 one-to-one bits", a_val);

        // R5: new data without a fall is not loaded
        shift_data = b_val;
        tick();
        check("R5 no repeat transfer", a_val);
        tick();
        check("R5 second bare tick", a_val);

        // R7: masking by mode keeps stored bits
        drive_mode = 2'd1;
        step(1);
        check("R7 one bank", a_val & {64'h0, 32'hFFFF_FFFF});
        drive_mode = 2'd2;
        step(1);
        check("R7 two banks", a_val & {32'h0, 64'hFFFF_FFFF_FFFF_FFFF});
        drive_mode = 2'd0;
        step(1);
        check("R7 off", '0);
        drive_mode = 2'd3;
        step(1);
        check("R7 widened restores", a_val);

        // R8: pending survives a new rise of the enable
        c_val = 96'hFFFF_0000_FFFF_0000_FFFF_0000;
        shift_data = c_val;
        en_up();
        en_down();
        en_up();
        tick();
        check("R8 tick with enable re-raised", a_val);
        d_val = 96'h8000_0000_0000_0000_0000_0001;
        shift_data = d_val;
        en_down();
        tick();
        check("R8 load after second fall", d_val);
        check_model("R8 model agrees");

        // Random rounds
        for (int i = 0; i < 200; i++) begin
            int unsigned act;
            act = $urandom % 4;
            shift_data = rnd96();
            case (act)
                0: begin
                    en_up();
                    en_down();
                end
                1: begin
                    en_up();
                    tick();
                    check_model("R3 random tick during shift");
                    en_down();
                end
                2: begin
                    step(1);
                end
                default: begin
                    drive_mode = 2'($urandom % 4);
                    step(1);
                    check_model("R7 random mode");
                end
            endcase
            if (($urandom % 2) == 0) begin
                tick();
                check_model("R5 random after tick");
            end else begin
                step(1);
                check_model("R4 random no tick");
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule